// File: doc/BRIEF.md
# Trap Condition and Exception-Entry Unit

This block is one purely combinational stage of the trap functional unit in a 64-bit processor. It handles two jobs. The first is the conditional trap. Two register operands are compared signed and unsigned. The compare outcomes are qualified by a 5-bit condition mask, and together with any raised cause bits they decide whether a trap is taken. The second job is exception entry. When a trap is taken, or when a system call is issued, the unit computes four values: the new machine state word, the saved program counter, the saved status word and the address to fetch next. Each of these outputs has its own valid flag.

Bit positions in the state words follow an MSB-first numbering. Architectural bit `n` of a 64-bit word sits at vector index `63-n`. The surrounding pipeline supplies the operation code, the operands, the mode flag, the mask, the cause vector, the current state word, the current instruction address and the vector base. It commits the outputs whose valid flag is high.

Top module: `trap_entry_unit`

## Requirements
- R1: Architectural bit n of every 64-bit state word maps to port index 63-n. For example, with a zero state word on trap entry, `msr_new` is 64'h8000_0000_0000_0001, and a plain trap gives `save_st` = 64'h0000_0000_0002_0000.
- R2: In 64-bit mode, `cond_mask` bits select compare outcomes of the full operands: bit 0 unsigned A>B, bit 1 unsigned A<B, bit 2 A==B, bit 3 signed A>B, bit 4 signed A<B.
- R3: When `mode32` is 1, the signed compares use the low 32 bits of each operand sign-extended, and the unsigned and equality compares use the low 32 bits zero-extended. The upper halves are ignored.
- R4: With `op_code` = 1 (conditional trap), a trap is taken when `cause_vec` is nonzero or when the compare outcomes ANDed with `cond_mask` are nonzero. When no trap is taken, all four valid flags are 0 and all four data outputs are 0.
- R5: On a taken trap, `save_pc` equals `pc_cur` and `next_pc` equals `vec_base` shifted left by 4, truncated to 64 bits. All four valid flags are 1.
- R6: On any entry (trap or system call), `msr_new` is `msr_cur` with architectural bits 5, 31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 58, 59, 60 and 62 cleared, and bits 0 and 63 set.
- R7: On a taken trap, `save_st` is `msr_cur` with bits 33..36 and 42 cleared. Bit 43 takes cause bit 0, bit 44 takes cause bit 4, bit 45 takes cause bit 1, and bit 47 takes cause bit 3. Bit 46 is 1 exactly when `cause_vec` is zero. Cause bit 2 sets no status bit.
- R8: With `op_code` = 2 (system call), all valid flags are 1, `save_pc` is `pc_cur`+4 wrapping modulo 2^64, and `next_pc` is `vec_base` shifted left by 4. `save_st` is `msr_cur` with bits 33..36 and 42..47 cleared and every other bit copied. Operands, mask and cause have no effect.
- R9: Any `op_code` other than 1 or 2 leaves all valid flags at 0 and all data outputs at 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 3 | Operation: 1 conditional trap, 2 system call, others idle |
| opnd_a | input | 64 | First compare operand |
| opnd_b | input | 64 | Second compare operand |
| mode32 | input | 1 | Compare on low 32 bits |
| cond_mask | input | 5 | Selects compare outcomes that trigger a trap |
| cause_vec | input | 5 | Raised exception causes; nonzero forces a trap |
| msr_cur | input | 64 | Current machine state word |
| pc_cur | input | 64 | Address of the current instruction |
| vec_base | input | 64 | Trap vector base, scaled by 16 |
| msr_new | output | 64 | New machine state word |
| msr_vld | output | 1 | `msr_new` is valid |
| save_pc | output | 64 | Value for the saved-PC register |
| save_pc_vld | output | 1 | `save_pc` is valid |
| save_st | output | 64 | Value for the saved-status register |
| save_st_vld | output | 1 | `save_st` is valid |
| next_pc | output | 64 | Next fetch address |
| next_pc_vld | output | 1 | `next_pc` is valid |

## Verification
The bound checker holds several properties on every evaluation. The four valid flags always agree, and the outputs are zero when they are low. The forced and cleared state bits hold on every entry, and the cleared status bits hold as well. On a system call, all six cause positions in the status word are zero. The vector and saved-PC values follow the operation, and a nonzero cause always fires the trap. The checker has no independent compare, so only the bench scenarios show that each mask bit picks the right signed or unsigned outcome. The same goes for the 32-bit sign and zero extension, and for the exact placement of each cause bit. The bench also covers the pc+4 wraparound and the MSB-first numbering at concrete values.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned NCOND  = 5;
  localparam int unsigned NCAUSE = 5;

  typedef enum logic [2:0] {
    OPC_IDLE    = 3'd0,
    OPC_TRAP    = 3'd1,
    OPC_SYSCALL = 3'd2
  } opc_e;

  // compare vector positions, LSB first
  localparam int unsigned CMP_GTU = 0;
  localparam int unsigned CMP_LTU = 1;
  localparam int unsigned CMP_EQ  = 2;
  localparam int unsigned CMP_GTS = 3;
  localparam int unsigned CMP_LTS = 4;

  // cause vector positions
  localparam int unsigned CAUSE_FPU  = 0;
  localparam int unsigned CAUSE_PRIV = 1;
  localparam int unsigned CAUSE_ADDR = 3;
  localparam int unsigned CAUSE_ILL  = 4;

  // architectural (MSB-first) state bit positions
  localparam int unsigned ARB_WIDE     = 0;
  localparam int unsigned ARB_UNDEF    = 5;
  localparam int unsigned ARB_TXN      = 31;
  localparam int unsigned ARB_VECU     = 38;
  localparam int unsigned ARB_VSXU     = 40;
  localparam int unsigned ARB_EXTINT   = 48;
  localparam int unsigned ARB_USER     = 49;
  localparam int unsigned ARB_FPU      = 50;
  localparam int unsigned ARB_FPX0     = 52;
  localparam int unsigned ARB_TRC_LO   = 53;
  localparam int unsigned ARB_TRC_HI   = 54;
  localparam int unsigned ARB_FPX1     = 55;
  localparam int unsigned ARB_IXLATE   = 58;
  localparam int unsigned ARB_DXLATE   = 59;
  localparam int unsigned ARB_PMON     = 60;
  localparam int unsigned ARB_RECOV    = 62;
  localparam int unsigned ARB_LITTLE   = 63;

  // status word positions
  localparam int unsigned ST_RSV_LO  = 33;
  localparam int unsigned ST_RSV_HI  = 36;
  localparam int unsigned ST_TXBAD   = 42;
  localparam int unsigned ST_FPU     = 43;
  localparam int unsigned ST_ILL     = 44;
  localparam int unsigned ST_PRIV    = 45;
  localparam int unsigned ST_PLAIN   = 46;
  localparam int unsigned ST_ADDR    = 47;

  localparam int unsigned VEC_SHIFT  = 4;
  localparam int unsigned INSN_BYTES = 4;

  function automatic int unsigned hw_idx(input int unsigned n);
    return XLEN - 1 - n;
  endfunction

  function automatic logic [XLEN-1:0] pos_mask(input int unsigned n);
    logic [XLEN-1:0] r;
    r = '0;
    r[XLEN-1-n] = 1'b1;
    return r;
  endfunction

  localparam logic [XLEN-1:0] ENTRY_CLR =
    pos_mask(ARB_UNDEF)  | pos_mask(ARB_TXN)    | pos_mask(ARB_VECU)   |
    pos_mask(ARB_VSXU)   | pos_mask(ARB_EXTINT) | pos_mask(ARB_USER)   |
    pos_mask(ARB_FPU)    | pos_mask(ARB_FPX0)   | pos_mask(ARB_TRC_LO) |
    pos_mask(ARB_TRC_HI) | pos_mask(ARB_FPX1)   | pos_mask(ARB_IXLATE) |
    pos_mask(ARB_DXLATE) | pos_mask(ARB_PMON)   | pos_mask(ARB_RECOV);

  localparam logic [XLEN-1:0] ENTRY_SET = pos_mask(ARB_WIDE) | pos_mask(ARB_LITTLE);

  function automatic logic [XLEN-1:0] entry_state(input logic [XLEN-1:0] m);
    return (m & ~ENTRY_CLR) | ENTRY_SET;
  endfunction
endpackage

// File: rtl/trap_cmp.sv
module trap_cmp #(
  parameter int unsigned W     = 64,
  parameter int unsigned NCOND = 5
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             narrow,
  output logic [NCOND-1:0] cmp
);
  localparam int unsigned HALF = W / 2;

  function automatic logic [W-1:0] sext_half(input logic [W-1:0] v);
    return {{(W-HALF){v[HALF-1]}}, v[HALF-1:0]};
  endfunction

  function automatic logic [W-1:0] zext_half(input logic [W-1:0] v);
    return {{(W-HALF){1'b0}}, v[HALF-1:0]};
  endfunction

  logic signed [W-1:0] sa, sb;
  logic        [W-1:0] ua, ub;

  always_comb begin
    sa = narrow ? sext_half(a) : a;
    sb = narrow ? sext_half(b) : b;
    ua = narrow ? zext_half(a) : a;
    ub = narrow ? zext_half(b) : b;
  end

  always_comb begin
    cmp = '0;
    cmp[trap_pkg::CMP_GTU] = ua > ub;
    cmp[trap_pkg::CMP_LTU] = ua < ub;
    cmp[trap_pkg::CMP_EQ]  = ua == ub;
    cmp[trap_pkg::CMP_GTS] = sa > sb;
    cmp[trap_pkg::CMP_LTS] = sa < sb;
  end
endmodule

// File: rtl/trap_decide.sv
module trap_decide #(
  parameter int unsigned NCOND  = 5,
  parameter int unsigned NCAUSE = 5
) (
  input  logic [2:0]        op_code,
  input  logic [NCOND-1:0]  cmp,
  input  logic [NCOND-1:0]  mask,
  input  logic [NCAUSE-1:0] cause,
  output logic              cond_hit,
  output logic              trap_hit,
  output logic              sc_hit
);
  import trap_pkg::*;
  always_comb begin
    cond_hit = |(cmp & mask);
    trap_hit = (op_code == OPC_TRAP) && ((|cause) || cond_hit);
    sc_hit   = (op_code == OPC_SYSCALL);
  end
endmodule

// File: rtl/trap_state_gen.sv
module trap_state_gen #(
  parameter int unsigned W      = 64,
  parameter int unsigned NCAUSE = 5
) (
  input  logic [W-1:0]      msr_old,
  input  logic [NCAUSE-1:0] cause,
  input  logic              is_sc,
  output logic [W-1:0]      msr_out,
  output logic [W-1:0]      status
);
  import trap_pkg::*;

  function automatic logic [W-1:0] form_status(input logic [W-1:0] m,
                                               input logic [NCAUSE-1:0] c,
                                               input logic sc);
    logic [W-1:0] r;
    r = m;
    for (int n = ST_RSV_LO; n <= ST_RSV_HI; n++) r[hw_idx(n)] = 1'b0;
    r[hw_idx(ST_TXBAD)] = 1'b0;
    if (sc) begin
      for (int n = ST_FPU; n <= ST_ADDR; n++) r[hw_idx(n)] = 1'b0;
    end else begin
      r[hw_idx(ST_FPU)]   = c[CAUSE_FPU];
      r[hw_idx(ST_ILL)]   = c[CAUSE_ILL];
      r[hw_idx(ST_PRIV)]  = c[CAUSE_PRIV];
      r[hw_idx(ST_PLAIN)] = (c == '0);
      r[hw_idx(ST_ADDR)]  = c[CAUSE_ADDR];
    end
    return r;
  endfunction

  always_comb begin
    msr_out = entry_state(msr_old);
    status  = form_status(msr_old, cause, is_sc);
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int unsigned XLEN   = trap_pkg::XLEN,
  parameter int unsigned NCOND  = trap_pkg::NCOND,
  parameter int unsigned NCAUSE = trap_pkg::NCAUSE
) (
  input  logic [2:0]        op_code,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  input  logic              mode32,
  input  logic [NCOND-1:0]  cond_mask,
  input  logic [NCAUSE-1:0] cause_vec,
  input  logic [XLEN-1:0]   msr_cur,
  input  logic [XLEN-1:0]   pc_cur,
  input  logic [XLEN-1:0]   vec_base,
  output logic [XLEN-1:0]   msr_new,
  output logic              msr_vld,
  output logic [XLEN-1:0]   save_pc,
  output logic              save_pc_vld,
  output logic [XLEN-1:0]   save_st,
  output logic              save_st_vld,
  output logic [XLEN-1:0]   next_pc,
  output logic              next_pc_vld
);
  import trap_pkg::*;

  logic [NCOND-1:0] cmp_vec;
  logic             cond_hit, trap_hit, sc_hit, entry_fire;
  logic [XLEN-1:0]  msr_calc, st_calc;

  trap_cmp #(.W(XLEN), .NCOND(NCOND)) u_cmp (
    .a(opnd_a), .b(opnd_b), .narrow(mode32), .cmp(cmp_vec)
  );

  trap_decide #(.NCOND(NCOND), .NCAUSE(NCAUSE)) u_dec (
    .op_code(op_code), .cmp(cmp_vec), .mask(cond_mask), .cause(cause_vec),
    .cond_hit(cond_hit), .trap_hit(trap_hit), .sc_hit(sc_hit)
  );

  trap_state_gen #(.W(XLEN), .NCAUSE(NCAUSE)) u_st (
    .msr_old(msr_cur), .cause(cause_vec), .is_sc(sc_hit),
    .msr_out(msr_calc), .status(st_calc)
  );

  assign entry_fire = trap_hit | sc_hit;

  always_comb begin
    msr_vld     = entry_fire;
    save_pc_vld = entry_fire;
    save_st_vld = entry_fire;
    next_pc_vld = entry_fire;
    msr_new     = entry_fire ? msr_calc : '0;
    save_st     = entry_fire ? st_calc  : '0;
    next_pc     = entry_fire ? (vec_base << VEC_SHIFT) : '0;
    if (sc_hit)        save_pc = pc_cur + XLEN'(INSN_BYTES);
    else if (trap_hit) save_pc = pc_cur;
    else               save_pc = '0;
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk (
  input logic [2:0]  op_code,
  input logic [4:0]  cause_vec,
  input logic [63:0] msr_cur,
  input logic [63:0] pc_cur,
  input logic [63:0] vec_base,
  input logic [63:0] msr_new,
  input logic        msr_vld,
  input logic [63:0] save_pc,
  input logic        save_pc_vld,
  input logic [63:0] save_st,
  input logic        save_st_vld,
  input logic [63:0] next_pc,
  input logic        next_pc_vld,
  input logic        trap_hit,
  input logic        sc_hit
);
  import trap_pkg::*;

  always_comb begin
    AST_FLAGS_AGREE: assert ((msr_vld == save_pc_vld) && (msr_vld == save_st_vld) &&
                             (msr_vld == next_pc_vld)) else $error("flags differ"); // R4
    if (!msr_vld) begin
      AST_IDLE_ZERO: assert ((msr_new | save_pc | save_st | next_pc) == '0)
        else $error("data not zero when idle"); // R4
    end
    if (msr_vld) begin
      AST_SET_BITS: assert (msr_new[hw_idx(ARB_WIDE)] && msr_new[hw_idx(ARB_LITTLE)])
        else $error("forced bits not set"); // R6
      AST_CLR_BITS: assert (!msr_new[hw_idx(ARB_USER)] && !msr_new[hw_idx(ARB_EXTINT)] &&
                            !msr_new[hw_idx(ARB_TRC_LO)] && !msr_new[hw_idx(ARB_TRC_HI)])
        else $error("cleared bits set"); // R6
      AST_STATUS_RSV: assert (save_st[hw_idx(33):hw_idx(36)] == 4'h0 && !save_st[hw_idx(42)])
        else $error("status reserved bits"); // R7
      AST_VECTOR: assert (next_pc == {vec_base[59:0], 4'h0}) else $error("vector"); // R5
    end
    if (msr_vld && op_code == 3'd1) begin
      AST_TRAP_SAVEPC: assert (save_pc == pc_cur) else $error("trap save pc"); // R5
    end
    if (op_code == 3'd1 && cause_vec == 5'd0 && msr_vld) begin
      AST_PLAIN_BIT: assert (save_st[hw_idx(46)]) else $error("plain bit"); // R7
    end
    if (op_code == 3'd1 && cause_vec != 5'd0) begin
      AST_CAUSE_FORCES: assert (msr_vld && trap_hit) else $error("cause ignored"); // R4
    end
    if (op_code == 3'd2) begin
      AST_SC_FIRE: assert (msr_vld && sc_hit && save_pc == pc_cur + 64'd4)
        else $error("syscall entry"); // R8
      AST_SC_STATUS: assert (save_st[hw_idx(42):hw_idx(47)] == 6'h0)
        else $error("syscall status"); // R8
    end
    if (op_code != 3'd1 && op_code != 3'd2) begin
      AST_UNKNOWN_IDLE: assert (!msr_vld && !trap_hit && !sc_hit)
        else $error("unknown op fired"); // R9
    end
  end
endmodule

bind trap_entry_unit trap_entry_chk u_chk (
  .op_code(op_code), .cause_vec(cause_vec), .msr_cur(msr_cur), .pc_cur(pc_cur),
  .vec_base(vec_base), .msr_new(msr_new), .msr_vld(msr_vld), .save_pc(save_pc),
  .save_pc_vld(save_pc_vld), .save_st(save_st), .save_st_vld(save_st_vld),
  .next_pc(next_pc), .next_pc_vld(next_pc_vld), .trap_hit(trap_hit), .sc_hit(sc_hit)
);

// File: tb/trap_entry_unit_test.sv
`timescale 1ns/1ps
module trap_entry_unit_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]  op_code;
  logic [63:0] opnd_a, opnd_b, msr_cur, pc_cur, vec_base;
  logic        mode32;
  logic [4:0]  cond_mask, cause_vec;
  logic [63:0] msr_new, save_pc, save_st, next_pc;
  logic        msr_vld, save_pc_vld, save_st_vld, next_pc_vld;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 1'b0;

  trap_entry_unit uut (
    .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b), .mode32(mode32),
    .cond_mask(cond_mask), .cause_vec(cause_vec), .msr_cur(msr_cur),
    .pc_cur(pc_cur), .vec_base(vec_base), .msr_new(msr_new), .msr_vld(msr_vld),
    .save_pc(save_pc), .save_pc_vld(save_pc_vld), .save_st(save_st),
    .save_st_vld(save_st_vld), .next_pc(next_pc), .next_pc_vld(next_pc_vld)
  );

  // reference model, written from the requirements
  function automatic int ab(input int n); return 63 - n; endfunction

  function automatic logic [63:0] ref_msr(input logic [63:0] m);
    int clr_list[15] = '{62, 60, 59, 58, 55, 54, 53, 52, 50, 49, 48, 40, 38, 31, 5};
    logic [63:0] r = m;
    foreach (clr_list[i]) r[ab(clr_list[i])] = 1'b0;
    r[ab(0)]  = 1'b1;
    r[ab(63)] = 1'b1;
    return r;
  endfunction

  function automatic logic [63:0] ref_status(input logic [63:0] m, input logic [4:0] c,
                                             input bit sc);
    logic [63:0] r = m;
    for (int n = 33; n <= 36; n++) r[ab(n)] = 1'b0;
    r[ab(42)] = 1'b0;
    if (sc) begin
      for (int n = 43; n <= 47; n++) r[ab(n)] = 1'b0;
    end else begin
      r[ab(47)] = c[3];
      r[ab(46)] = (c == 5'd0);
      r[ab(45)] = c[1];
      r[ab(44)] = c[4];
      r[ab(43)] = c[0];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic n32, input logic [4:0] mk, input logic [4:0] cs,
                       input logic [63:0] m, input logic [63:0] pc, input logic [63:0] vb);
    @(posedge clk); #1;
    op_code = op; opnd_a = a; opnd_b = b; mode32 = n32; cond_mask = mk;
    cause_vec = cs; msr_cur = m; pc_cur = pc; vec_base = vb;
    @(negedge clk);
  endtask

  // kind: 0 none, 1 trap, 2 system call
  task automatic expect_entry(input string tag, input int kind);
    logic [3:0] flags = {msr_vld, save_pc_vld, save_st_vld, next_pc_vld};
    if (kind == 0) begin
      chk({tag, " flags"}, {60'd0, flags}, 64'd0);
      chk({tag, " data"}, msr_new | save_pc | save_st | next_pc, 64'd0);
    end else begin
      chk({tag, " flags"}, {60'd0, flags}, 64'hF);
      chk({tag, " msr"}, msr_new, ref_msr(msr_cur));
      chk({tag, " savepc"}, save_pc, (kind == 2) ? pc_cur + 64'd4 : pc_cur);
      chk({tag, " status"}, save_st, ref_status(msr_cur, cause_vec, kind == 2));
      chk({tag, " next"}, next_pc, {vec_base[59:0], 4'd0});
    end
  endtask

  localparam logic [63:0] M1 = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] PC = 64'h0000_0000_1000_2000;
  localparam logic [63:0] VB = 64'h0000_0000_0000_0070;

  task automatic t_idle;  // R9 at start-up
    drive(3'd0, 64'd1, 64'd1, 1'b0, 5'h1F, 5'h1F, M1, PC, VB);
    expect_entry("R9 idle", 0);
  endtask

  task automatic t_cmp_wide;  // R2
    drive(3'd1, 64'd5, 64'd3, 1'b0, 5'b00001, 5'd0, M1, PC, VB); expect_entry("R2 gtu", 1);
    drive(3'd1, 64'd5, 64'd3, 1'b0, 5'b00010, 5'd0, M1, PC, VB); expect_entry("R2 ltu miss", 0);
    drive(3'd1, 64'd5, 64'd3, 1'b0, 5'b01000, 5'd0, M1, PC, VB); expect_entry("R2 gts", 1);
    drive(3'd1, '1, 64'd1, 1'b0, 5'b10000, 5'd0, M1, PC, VB);    expect_entry("R2 lts", 1);
    drive(3'd1, '1, 64'd1, 1'b0, 5'b01010, 5'd0, M1, PC, VB);    expect_entry("R2 sign miss", 0);
    drive(3'd1, '1, 64'd1, 1'b0, 5'b00001, 5'd0, M1, PC, VB);    expect_entry("R2 gtu neg", 1);
    drive(3'd1, 64'd9, 64'd9, 1'b0, 5'b00100, 5'd0, M1, PC, VB); expect_entry("R2 eq", 1);
    drive(3'd1, 64'd9, 64'd9, 1'b0, 5'b11011, 5'd0, M1, PC, VB); expect_entry("R2 eq miss", 0);
  endtask

  task automatic t_cmp_narrow;  // R3
    drive(3'd1, 64'h1234_5678_8000_0000, 64'd1, 1'b1, 5'b10000, 5'd0, M1, PC, VB);
    expect_entry("R3 lts narrow", 1);
    drive(3'd1, 64'h1234_5678_8000_0000, 64'd1, 1'b0, 5'b10000, 5'd0, M1, PC, VB);
    expect_entry("R3 lts wide miss", 0);
    drive(3'd1, 64'h1234_5678_8000_0000, 64'd1, 1'b1, 5'b00001, 5'd0, M1, PC, VB);
    expect_entry("R3 gtu narrow", 1);
    drive(3'd1, 64'hAAAA_0000_0000_0007, 64'h5555_0000_0000_0007, 1'b1, 5'b00100, 5'd0, M1, PC, VB);
    expect_entry("R3 eq narrow", 1);
    drive(3'd1, 64'hAAAA_0000_0000_0007, 64'h5555_0000_0000_0007, 1'b0, 5'b00100, 5'd0, M1, PC, VB);
    expect_entry("R3 eq wide miss", 0);
  endtask

  task automatic t_entry_fields;  // R1 R5 R6 R7
    drive(3'd1, 64'd4, 64'd4, 1'b0, 5'b00100, 5'd0, 64'd0, PC, VB);
    chk("R1 msr numbering", msr_new, 64'h8000_0000_0000_0001);
    chk("R1 R7 plain bit", save_st, 64'h0000_0000_0002_0000);
    chk("R5 next", next_pc, 64'h0000_0000_0000_0700);
    drive(3'd1, 64'd4, 64'd4, 1'b0, 5'b00100, 5'd0, '1, PC, VB);
    expect_entry("R6 R7 ones", 1);
    drive(3'd1, 64'd0, 64'd1, 1'b0, 5'd0, 5'b00001, 64'd0, PC, 64'hF000_0000_0000_0123);
    chk("R7 fpu cause", save_st, 64'h0000_0000_0010_0000);
    chk("R5 vector trunc", next_pc, 64'h0000_0000_0000_1230);
    drive(3'd1, 64'd0, 64'd1, 1'b0, 5'd0, 5'b00100, 64'd0, PC, VB);
    chk("R7 cause2 silent", save_st, 64'd0);
    chk("R4 cause forces", {63'd0, msr_vld}, 64'd1);
    for (int k = 0; k < 32; k++) begin
      drive(3'd1, 64'd0, 64'd1, 1'b0, 5'd0, 5'(k), M1, PC, VB);
      expect_entry("R7 cause sweep", (k == 0) ? 0 : 1);
    end
  endtask

  task automatic t_syscall;  // R8
    drive(3'd2, 64'd0, 64'd1, 1'b0, 5'd0, 5'h1F, '1, 64'hFFFF_FFFF_FFFF_FFFC, VB);
    chk("R8 wrap", save_pc, 64'd0);
    expect_entry("R8 sc ones", 2);
    drive(3'd2, 64'd3, 64'd3, 1'b1, 5'h1F, 5'd0, M1, PC, VB);
    expect_entry("R8 sc mixed", 2);
  endtask

  task automatic t_unknown;  // R9
    for (int op = 3; op < 8; op++) begin
      drive(3'(op), 64'd2, 64'd2, 1'b0, 5'h1F, 5'h1F, '1, PC, VB);
      expect_entry("R9 unknown op", 0);
    end
  endtask

  initial begin
    t_idle();
    t_cmp_wide();
    t_cmp_narrow();
    t_entry_fields();
    t_syscall();
    t_unknown();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule